// File: doc/BRIEF.md
# PWM Fault Protection Controller

This block sits between four fault inputs that a glitch filter has already cleaned and the output stage of a motor-control PWM. For each fault channel it holds an event flag, an interrupt enable, a recovery-mode bit and a shutdown state. From these it drives one shutdown line per channel, which forces that channel's group of PWM outputs inactive, and one combined interrupt request. A cycle-start pulse from the PWM counter marks the only moments at which a shut-down channel may come back.

Software reaches the block through a small register port. A write strobe with a two-bit address and a four-bit data word writes it, and a combinational read mux reads it. The register port is plain control and status: every write completes in the cycle its strobe is high, and no transfer is ever held back, so the block has no valid/ready handshake. Each channel recovers in one of two ways. In automatic mode the channel returns as soon as a cycle starts with its fault low. In manual mode software must first clear the flag. After that, channels 1 and 3 (indices 0 and 2) return at the next cycle start even if their pin is still high, while channels 2 and 4 (indices 1 and 3) also need their pin low at that cycle start.

Top module: `pwm_fault_guard`

## Requirements
- R1: After reset every flag, interrupt latch, interrupt enable, mode bit and shutdown state is 0, so `pwm_off` = 0, `irq` = 0, and every register reads 0 when no fault is high.
- R2: Address 0 reads the live fault levels (bit i = channel i). A write to address 0 changes nothing.
- R3: A rising edge on `fault_lvl[i]` sets flag bit i, which reads at address 1 after the next clock edge. The flag stays set while the level is held.
- R4: A write to address 1 clears each flag whose data bit is 1 and leaves flags with a 0 data bit alone. If a rising edge on a channel falls in the same cycle as its clear, the flag stays set.
- R5: Address 2 holds the interrupt enables. When bit i is 1, a rising edge on channel i sets that channel's interrupt latch, and `irq` (the OR over all enabled latches) is high after that edge.
- R6: A channel's interrupt latch is cleared when its flag is cleared through address 1, or when its enable is written to 0. In the second case `irq` falls after the write edge, the flag stays set, and re-enabling does not bring the request back.
- R7: A pulse on `vec_ack` changes neither `irq`, the flags, the enables nor `pwm_off`.
- R8: `pwm_off[i]` is high in the same cycle that `fault_lvl[i]` rises, in both modes. In automatic mode it stays high for as long as the fault level is high.
- R9: Address 3 holds the mode bits (0 = automatic, 1 = manual). In automatic mode a shut-down channel is released at the edge where `cyc_start` is high and its fault is low, whether or not its flag has been cleared.
- R10: In manual mode, channels 0 and 2 are released at a `cyc_start` edge once their flag is clear, whatever their fault level.
- R11: In manual mode, channels 1 and 3 are released at a `cyc_start` edge only if their flag is clear and their fault level is low.
- R12: In manual mode the flag must already be clear before the `cyc_start` edge. A flag clear in the same cycle as `cyc_start` does not release the channel until a later cycle start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_lvl | input | 4 | Filtered fault levels, one per channel |
| cyc_start | input | 1 | One-cycle pulse at the start of a PWM period |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 4 | Register write data, one bit per channel |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 4 | Register read data (combinational) |
| vec_ack | input | 1 | Interrupt vector-fetch acknowledge (has no effect on state) |
| pwm_off | output | 4 | Per-channel shutdown of the PWM output group |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench sweeps every channel, both modes, both pin levels at the cycle start, and acknowledged against unacknowledged flags. This catches a design that swaps the odd/even recovery rules, since it would release channel 1 with its pin high or hold channel 0 with a clear flag. It also catches a design that makes automatic mode wait for the acknowledge. A rising edge in the same cycle as its clear is aimed at designs that let the clear win and silently lose an event. Dropping the enable while a request is pending checks that the flag survives and that re-enabling does not resurrect the request. An acknowledge written in the same cycle as a cycle start shows whether a design uses the next-state flag instead of the stored one and releases too early.

// File: rtl/pfg_pkg.sv
package pfg_pkg;
  localparam int unsigned ADDR_W = 2;
  localparam logic [ADDR_W-1:0] REG_STAT = 2'd0;
  localparam logic [ADDR_W-1:0] REG_FLAG = 2'd1;
  localparam logic [ADDR_W-1:0] REG_IEN  = 2'd2;
  localparam logic [ADDR_W-1:0] REG_MODE = 2'd3;

  typedef enum logic {
    REC_AUTO   = 1'b0,
    REC_MANUAL = 1'b1
  } rec_mode_e;
endpackage

// File: rtl/pfg_regs.sv
module pfg_regs #(
  parameter int unsigned NUM_CH = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [pfg_pkg::ADDR_W-1:0] wr_addr,
  input  logic [NUM_CH-1:0]         wr_data,
  input  logic [pfg_pkg::ADDR_W-1:0] rd_addr,
  input  logic [NUM_CH-1:0]         stat_in,
  input  logic [NUM_CH-1:0]         flag_in,
  output logic [NUM_CH-1:0]         ack_pulse,
  output logic [NUM_CH-1:0]         ien_q,
  output logic [NUM_CH-1:0]         mode_q,
  output logic [NUM_CH-1:0]         rd_data
);
  import pfg_pkg::*;

  logic sel_flag, sel_ien, sel_mode;

  assign sel_flag = wr_en && (wr_addr == REG_FLAG);
  assign sel_ien  = wr_en && (wr_addr == REG_IEN);
  assign sel_mode = wr_en && (wr_addr == REG_MODE);

  // write-one strobes toward the channels; zero bits do nothing
  assign ack_pulse = sel_flag ? wr_data : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q  <= '0;
      mode_q <= '0;
    end else begin
      if (sel_ien)  ien_q  <= wr_data;
      if (sel_mode) mode_q <= wr_data;
    end
  end

  // status is the pin level itself, so a write there has nowhere to land
  always_comb begin
    unique case (rd_addr)
      REG_STAT: rd_data = stat_in;
      REG_FLAG: rd_data = flag_in;
      REG_IEN:  rd_data = ien_q;
      default:  rd_data = mode_q;
    endcase
  end
endmodule

// File: rtl/pfg_channel.sv
module pfg_channel #(
  parameter bit FREE_RELEASE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fault,
  input  logic cyc_start,
  input  logic ack,
  input  logic ien,
  input  logic manual,
  output logic flag_q,
  output logic req_q,
  output logic off
);
  logic prev_q;
  logic dis_q;
  logic rise;
  logic shut_set;
  logic pin_ok;
  logic release_ok;
  logic flag_clear;

  assign rise       = fault & ~prev_q;
  assign flag_clear = ack & ~rise;

  // the manual-mode pin condition depends on which pair the channel belongs to
  generate
    if (FREE_RELEASE) begin : g_free
      assign pin_ok = 1'b1;
    end else begin : g_need_low
      assign pin_ok = ~fault;
    end
  endgenerate

  assign shut_set   = manual ? rise : fault;
  assign release_ok = cyc_start & (manual ? (~flag_q & pin_ok) : ~fault);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      flag_q <= 1'b0;
      req_q  <= 1'b0;
      dis_q  <= 1'b0;
    end else begin
      prev_q <= fault;

      if (rise)            flag_q <= 1'b1;
      else if (flag_clear) flag_q <= 1'b0;

      if (!ien)            req_q <= 1'b0;
      else if (rise)       req_q <= 1'b1;
      else if (flag_clear) req_q <= 1'b0;

      if (shut_set)        dis_q <= 1'b1;
      else if (release_ok) dis_q <= 1'b0;
    end
  end

  assign off = dis_q | shut_set;
endmodule

// File: rtl/pwm_fault_guard.sv
module pwm_fault_guard #(
  parameter int unsigned NUM_CH = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_CH-1:0]           fault_lvl,
  input  logic                        cyc_start,
  input  logic                        wr_en,
  input  logic [pfg_pkg::ADDR_W-1:0]  wr_addr,
  input  logic [NUM_CH-1:0]           wr_data,
  input  logic [pfg_pkg::ADDR_W-1:0]  rd_addr,
  output logic [NUM_CH-1:0]           rd_data,
  input  logic                        vec_ack,
  output logic [NUM_CH-1:0]           pwm_off,
  output logic                        irq
);
  logic [NUM_CH-1:0] evt_flag;
  logic [NUM_CH-1:0] req_latch;
  logic [NUM_CH-1:0] ack_pulse;
  logic [NUM_CH-1:0] ien_q;
  logic [NUM_CH-1:0] mode_q;
  logic              vec_ack_unused;

  // a vector fetch is observed but deliberately drives no state
  assign vec_ack_unused = vec_ack;

  pfg_regs #(.NUM_CH(NUM_CH)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .stat_in   (fault_lvl),
    .flag_in   (evt_flag),
    .ack_pulse (ack_pulse),
    .ien_q     (ien_q),
    .mode_q    (mode_q),
    .rd_data   (rd_data)
  );

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      localparam bit FREE = ((i % 2) == 0);
      pfg_channel #(.FREE_RELEASE(FREE)) u_ch (
        .clk       (clk),
        .rst_n     (rst_n),
        .fault     (fault_lvl[i]),
        .cyc_start (cyc_start),
        .ack       (ack_pulse[i]),
        .ien       (ien_q[i]),
        .manual    (mode_q[i]),
        .flag_q    (evt_flag[i]),
        .req_q     (req_latch[i]),
        .off       (pwm_off[i])
      );
    end
  endgenerate

  assign irq = |(req_latch & ien_q);
endmodule

// File: rtl/pfg_checker.sv
module pfg_checker #(
  parameter int unsigned NUM_CH = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [NUM_CH-1:0]          fault_lvl,
  input logic                       cyc_start,
  input logic                       wr_en,
  input logic [pfg_pkg::ADDR_W-1:0] wr_addr,
  input logic [NUM_CH-1:0]          wr_data,
  input logic [NUM_CH-1:0]          pwm_off,
  input logic                       irq,
  input logic [NUM_CH-1:0]          evt_flag,
  input logic [NUM_CH-1:0]          mode_q
);
  import pfg_pkg::*;

  p_irq_needs_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|evt_flag));

  p_ien_off_drops_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == REG_IEN && wr_data == '0) |=> !irq);

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
      p_edge_sets_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_lvl[i]) |=> evt_flag[i]);

      p_edge_shuts_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_lvl[i]) |-> pwm_off[i]);

      p_auto_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q[i] && fault_lvl[i]) |-> pwm_off[i]);

      p_manual_release_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[i] && $past(mode_q[i]) && $fell(pwm_off[i]))
          |-> ($past(cyc_start) && !$past(evt_flag[i])));

      if ((i % 2) == 1) begin : g_even_pin
        p_pin_low_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
          (mode_q[i] && $past(mode_q[i]) && $fell(pwm_off[i]))
            |-> !$past(fault_lvl[i]));
      end
    end
  endgenerate
endmodule

bind pwm_fault_guard pfg_checker #(.NUM_CH(NUM_CH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .fault_lvl (fault_lvl),
  .cyc_start (cyc_start),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .pwm_off   (pwm_off),
  .irq       (irq),
  .evt_flag  (evt_flag),
  .mode_q    (mode_q)
);

// File: tb/pwm_fault_guard_test.sv
`timescale 1ns/1ps
module pwm_fault_guard_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] fault_lvl = '0;
  logic       cyc_start = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [3:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [3:0] rd_data;
  logic       vec_ack = 1'b0;
  logic [3:0] pwm_off;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pwm_fault_guard uut (
    .clk(clk), .rst_n(rst_n), .fault_lvl(fault_lvl), .cyc_start(cyc_start),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .vec_ack(vec_ack), .pwm_off(pwm_off), .irq(irq)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [3:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic wr(input logic [1:0] a, input logic [3:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic pulse_start();
    cyc_start = 1'b1;
    tick();
    cyc_start = 1'b0;
    #1;
  endtask

  initial begin : watchdog
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin : stim
    logic [3:0] v;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    #1;
    chk("R1 pwm_off", pwm_off, 0);
    chk("R1 irq", irq, 0);
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v);
      chk("R1 reg", v, 0);
    end

    // R2 status follows pin, writes ignored
    wr(2'd0, 4'hF);
    rd(2'd0, v);
    chk("R2 write ignored", v, 0);
    fault_lvl = 4'b0101;
    rd(2'd0, v);
    chk("R2 live level", v, 5);
    fault_lvl = '0;
    tick();
    wr(2'd1, 4'hF);
    pulse_start();

    // sweep: channel x mode x pin at start x acknowledged
    for (int ch = 0; ch < 4; ch++) begin
      for (int m = 0; m < 2; m++) begin
        for (int pin = 0; pin < 2; pin++) begin
          for (int ak = 0; ak < 2; ak++) begin
            int exp_off;
            wr(2'd3, m ? 4'hF : 4'h0);
            fault_lvl[ch] = 1'b1;
            #1;
            chk("R8 same-cycle shutdown", pwm_off[ch], 1);
            tick();
            rd(2'd1, v);
            chk("R3 flag set", v[ch], 1);
            if (ak != 0) begin
              wr(2'd1, 4'b0001 << ch);
              rd(2'd1, v);
              chk("R4 flag cleared", v[ch], 0);
            end
            fault_lvl[ch] = pin[0];
            tick();
            pulse_start();
            if (m == 0) exp_off = pin;
            else if (ak == 0) exp_off = 1;
            else if ((ch % 2) == 0) exp_off = 0;
            else exp_off = pin;
            if (m == 0) chk("R9 auto release", pwm_off[ch], exp_off);
            else if ((ch % 2) == 0) chk("R10 manual free", pwm_off[ch], exp_off);
            else chk("R11 manual pin low", pwm_off[ch], exp_off);
            if (m == 0 && ak == 0 && pin == 0) begin
              rd(2'd1, v);
              chk("R9 flag kept", v[ch], 1);
            end
            fault_lvl[ch] = 1'b0;
            tick();
            wr(2'd1, 4'hF);
            pulse_start();
            chk("R10 cleanup", pwm_off, 0);
          end
        end
      end
    end

    // R12 acknowledge in same cycle as cycle start
    wr(2'd3, 4'hF);
    fault_lvl[0] = 1'b1;
    tick();
    fault_lvl[0] = 1'b0;
    tick();
    wr_en = 1'b1; wr_addr = 2'd1; wr_data = 4'b0001; cyc_start = 1'b1;
    tick();
    wr_en = 1'b0; cyc_start = 1'b0;
    #1;
    chk("R12 same-cycle ack holds", pwm_off[0], 1);
    pulse_start();
    chk("R12 later start releases", pwm_off[0], 0);

    // R5 / R6 / R7 interrupt behaviour
    wr(2'd3, 4'h0);
    wr(2'd2, 4'hF);
    fault_lvl[2] = 1'b1;
    tick();
    #1;
    chk("R5 irq set", irq, 1);
    vec_ack = 1'b1;
    tick();
    vec_ack = 1'b0;
    #1;
    chk("R7 irq kept", irq, 1);
    chk("R7 pwm_off kept", pwm_off, 4'b0100);
    rd(2'd1, v);
    chk("R7 flags kept", v, 4'b0100);
    rd(2'd2, v);
    chk("R7 enables kept", v, 15);
    wr(2'd2, 4'h0);
    #1;
    chk("R6 irq off with enable", irq, 0);
    rd(2'd1, v);
    chk("R6 flag kept", v[2], 1);
    wr(2'd2, 4'hF);
    tick();
    #1;
    chk("R6 no resurrection", irq, 0);
    fault_lvl[1] = 1'b1;
    tick();
    #1;
    chk("R5 irq on ch1", irq, 1);
    wr(2'd1, 4'b0010);
    #1;
    chk("R6 ack clears irq", irq, 0);
    // R4 edge and clear in the same cycle
    fault_lvl[3] = 1'b1;
    wr(2'd1, 4'b1000);
    rd(2'd1, v);
    chk("R4 edge beats clear", v[3], 1);
    chk("R5 irq from ch3", irq, 1);
    wr(2'd1, 4'b0000);
    rd(2'd1, v);
    chk("R4 zero write no effect", v, 4'b1100);

    // R1 reset clears everything
    fault_lvl = '0;
    tick();
    rst_n = 1'b0;
    #1;
    chk("R1 reset irq", irq, 0);
    rd(2'd1, v);
    chk("R1 reset flags", v, 0);
    chk("R1 reset pwm_off", pwm_off, 0);
    rst_n = 1'b1;
    tick();

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule